// File: doc/BRIEF.md
# Binary Range-Weight 5x5 Window Array

This block takes a raster stream of 8-bit pixels, one per accepted beat, and forms a full 5x5 neighbourhood on every beat. Four previous lines sit in a single line store whose taps are chained, so each beat reads one column of four older rows. The incoming pixel completes that column. The five rows then shift right through a grid of registers. The register at the middle of the grid is the window centre, and every one of the 25 lanes compares against it.

Each lane forms the absolute difference between its pixel and the centre, with a 9-bit subtract, a sign test and a two's-complement negate. It compares that difference with a threshold supplied from outside for the current centre. The lane's weight bit is 1 when the difference is at or below the threshold. A weight of 1 passes the pixel through, and a weight of 0 outputs zero.

The centre row's stream is exported early, three beats ahead of its compare, so that an external generator can look up a threshold in time. A small sequencer tracks frame position. It flags a window valid only when the whole neighbourhood lies inside the frame. A single ready signal stalls the entire pipeline.

Top module: `bk_window_array`

## Requirements
- R1: During and right after reset, `win_valid` is 0 and every bit of `win_wt` and `win_pix` is 0.
- R2: `in_ready` equals `out_ready`. A beat is accepted exactly when `in_valid` and `out_ready` are both 1.
- R3: After the beat that follows the beat carrying pixel (x, y), lane r*5+j (r, j in 0..4) holds the pixel at column x-4+j, row y-4+r whenever its weight is 1. Lane 0 is top-left, lanes run left to right and then top to bottom, and lane i is `win_pix[8*i+7:8*i]` with weight `win_wt[i]`.
- R4: A lane's weight is 1 if and only if |lane pixel - centre pixel| <= `thr`. Here `thr` is the value present on the beat that produces the output, and the centre is lane 12.
- R5: A lane with weight 0 outputs pixel value 0.
- R6: The centre lane (12) always has weight 1 on a valid window.
- R7: `win_valid` rises after the beat that follows pixel (x, y) only when x >= 4 and y >= 4, with x and y counted from 0 within the frame. For all other positions it is 0.
- R8: While a pixel at (x, y) is offered, `ctr_tap` shows the pixel at (x, y-2). That pixel becomes the centre of the window compared on the third beat after this one, so its threshold must be on `thr` at that beat.
- R9: With `out_ready` low, all outputs hold. With `out_ready` high and `in_valid` low, `win_valid` is 0 on the next cycle.
- R10: After LINE_W*FRAME_H beats the position counters restart. The first four rows of the next frame produce no valid window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_pix | input | PIX_W | Incoming raster pixel |
| in_valid | input | 1 | `in_pix` is offered |
| in_ready | output | 1 | Block accepts a beat |
| ctr_tap | output | PIX_W | Early copy of the future centre pixel |
| thr | input | PIX_W | Threshold for the centre being compared this beat |
| win_pix | output | 25*PIX_W | Masked window pixels, lane 0 in the low bits |
| win_wt | output | 25 | Binary weight per lane |
| win_valid | output | 1 | Outputs hold a window fully inside the frame |
| out_ready | input | 1 | Consumer takes the output; low stalls everything |

## Verification
The bench builds the block with an 8-pixel line and a 6-row frame. That size lets several whole frames stream through in a few hundred beats. It also places every border case within reach: left and top exclusions, line wrap through the shift grid, and the restart into a second frame. Frame patterns put pixel differences exactly on the threshold, at a zero threshold, and at a half-range checkerboard. A threshold derived from the early tap checks the look-ahead timing, and a mid-frame stall and bubble check the hold behaviour.

// File: rtl/bk_window_array.sv
module bk_window_array #(
  parameter int PIX_W   = 8,
  parameter int LINE_W  = 1920,
  parameter int FRAME_H = 1080
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PIX_W-1:0]     in_pix,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic [PIX_W-1:0]     ctr_tap,
  input  logic [PIX_W-1:0]     thr,
  output logic [25*PIX_W-1:0]  win_pix,
  output logic [24:0]          win_wt,
  output logic                 win_valid,
  input  logic                 out_ready
);
  localparam int K  = 5;
  localparam int N  = K * K;
  localparam int XW = $clog2(LINE_W);
  localparam int YW = $clog2(FRAME_H);

  logic [XW-1:0] xc;
  logic [YW-1:0] yc;
  logic          inside_q;
  logic [(K-1)*PIX_W-1:0] lbuf [LINE_W];
  logic [(K-1)*PIX_W-1:0] rd;
  logic [PIX_W-1:0] col [K];
  logic [PIX_W-1:0] sh [K][K];
  logic [PIX_W-1:0] lane_v [N];
  logic             lane_h [N];
  logic [PIX_W-1:0] ctr;

  wire adv = in_valid & out_ready;
  assign in_ready = out_ready;
  assign rd       = lbuf[xc];
  assign ctr      = sh[K/2][K/2];
  assign ctr_tap  = col[K/2];

  for (genvar r = 0; r < K; r++) begin : g_col
    if (r == K-1) begin : g_new
      assign col[r] = in_pix;
    end else begin : g_old
      assign col[r] = rd[(K-2-r)*PIX_W +: PIX_W];
    end
  end

  for (genvar r = 0; r < K; r++) begin : g_row
    for (genvar j = 0; j < K; j++) begin : g_lane
      localparam int I = r*K + j;
      logic [PIX_W:0]   d;
      logic [PIX_W-1:0] mag;
      assign lane_v[I] = sh[r][K-1-j];
      assign d   = {1'b0, lane_v[I]} - {1'b0, ctr};
      assign mag = d[PIX_W] ? (~d[PIX_W-1:0] + 1'b1) : d[PIX_W-1:0];
      assign lane_h[I] = (mag <= thr);
    end
  end

  always_ff @(posedge clk) begin
    if (adv) lbuf[xc] <= {rd[(K-2)*PIX_W-1:0], in_pix};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < K; r++)
        for (int c = 0; c < K; c++) sh[r][c] <= '0;
      win_pix <= '0;
      win_wt  <= '0;
    end else if (adv) begin
      for (int r = 0; r < K; r++) begin
        sh[r][0] <= col[r];
        for (int c = 1; c < K; c++) sh[r][c] <= sh[r][c-1];
      end
      for (int i = 0; i < N; i++) begin
        win_pix[i*PIX_W +: PIX_W] <= lane_h[i] ? lane_v[i] : '0;
        win_wt[i] <= lane_h[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xc <= '0;
      yc <= '0;
      inside_q  <= 1'b0;
      win_valid <= 1'b0;
    end else begin
      if (adv) begin
        inside_q <= (xc >= XW'(K-1)) && (yc >= YW'(K-1));
        if (xc == XW'(LINE_W-1)) begin
          xc <= '0;
          yc <= (yc == YW'(FRAME_H-1)) ? '0 : yc + 1'b1;
        end else begin
          xc <= xc + 1'b1;
        end
      end
      if (out_ready) win_valid <= in_valid & inside_q;
    end
  end
endmodule

// File: rtl/bk_window_array_chk.sv
module bk_window_array_chk #(
  parameter int PIX_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                out_ready,
  input logic [25*PIX_W-1:0] win_pix,
  input logic [24:0]         win_wt,
  input logic                win_valid
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!win_valid && win_wt == '0));

  for (genvar i = 0; i < 25; i++) begin : g_z
    // R5
    zero_lane_chk: assert property (@(posedge clk) disable iff (rst)
      !win_wt[i] |-> (win_pix[i*PIX_W +: PIX_W] == '0));
  end

  // R6
  centre_pass_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> win_wt[12]);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_ready |=> ($stable(win_pix) && $stable(win_wt) && $stable(win_valid)));

  // R9
  bubble_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (out_ready && !in_valid) |=> !win_valid);
endmodule

bind bk_window_array bk_window_array_chk #(.PIX_W(PIX_W)) u_chk (.*);

// File: tb/bk_window_array_bench.sv
module bk_window_array_bench;
  localparam int W = 8;
  localparam int H = 6;
  // {ax, ay, c0, base, shift}
  localparam logic [39:0] PAT [4] = '{
    {8'd10,  8'd3,   8'd5,  8'd10,  8'd8},
    {8'd0,   8'd0,   8'd77, 8'd0,   8'd8},
    {8'd37,  8'd91,  8'd13, 8'd4,   8'd2},
    {8'd128, 8'd128, 8'd0,  8'd127, 8'd8}
  };

  logic clk = 0, rst = 1;
  logic [7:0] in_pix = 0, thr = 0, ctr_tap;
  logic in_valid = 0, out_ready = 1, in_ready, win_valid;
  logic [199:0] win_pix;
  logic [24:0]  win_wt;

  always #5 clk = ~clk;

  bk_window_array #(.PIX_W(8), .LINE_W(W), .FRAME_H(H)) u_bk_window_array (
    .clk(clk), .rst(rst), .in_pix(in_pix), .in_valid(in_valid), .in_ready(in_ready),
    .ctr_tap(ctr_tap), .thr(thr), .win_pix(win_pix), .win_wt(win_wt),
    .win_valid(win_valid), .out_ready(out_ready));

  int n_chk = 0, n_bad = 0;
  logic [7:0] img [H][W];
  int bx = 0, by = 0, fr = 0, ppx = 0, ppy = 0;
  bit pvld = 0;
  logic [7:0] tapq [3];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic beat(input logic [7:0] p, input logic [7:0] t);
    logic [7:0] ep [25];
    bit ew [25];
    bit evld;
    int c, dd;
    in_pix = p; thr = t; in_valid = 1; out_ready = 1;
    #1;
    if (by >= 2) chk(ctr_tap == img[by-2][bx], "R8 tap", ctr_tap, img[by-2][bx]);
    evld = pvld;
    if (evld) begin
      c = img[ppy-2][ppx-2];
      for (int i = 0; i < 25; i++) begin
        ep[i] = img[ppy-4+i/5][ppx-4+i%5];
        dd = int'(ep[i]) - c;
        if (dd < 0) dd = -dd;
        ew[i] = (dd <= int'(t));
      end
    end
    @(posedge clk); #2;
    if (fr > 0 && ppy < 4) chk(win_valid == evld, "R10 frame restart valid", win_valid, evld);
    else chk(win_valid == evld, "R7 window valid", win_valid, evld);
    if (evld) begin
      for (int i = 0; i < 25; i++) begin
        if (win_wt[i] != ew[i]) begin chk(0, "R4 weight", win_wt[i], ew[i]); break; end
        if (i == 24) chk(1, "R4", 0, 0);
      end
      for (int i = 0; i < 25; i++) begin
        logic [7:0] a = win_pix[i*8 +: 8];
        logic [7:0] e = ew[i] ? ep[i] : 8'd0;
        if (a != e) begin chk(0, ew[i] ? "R3 lane pixel" : "R5 zero lane", a, e); break; end
        if (i == 24) chk(1, "R3 R5", 0, 0);
      end
      chk(win_wt[12] == 1'b1, "R6 centre weight", win_wt[12], 1);
    end
    img[by][bx] = p;
    pvld = (bx >= 4 && by >= 4); ppx = bx; ppy = by;
    tapq[2] = tapq[1]; tapq[1] = tapq[0]; tapq[0] = ctr_tap;
    if (bx == W-1) begin bx = 0; by = (by == H-1) ? 0 : by + 1; if (by == 0) fr++; end
    else bx++;
  endtask

  task automatic stall_seq();
    logic [199:0] sp = win_pix;
    logic [24:0]  sw = win_wt;
    logic         sv = win_valid;
    in_valid = 1; out_ready = 0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2;
      chk(in_ready == 1'b0, "R2 ready low", in_ready, 0);
      chk(win_pix == sp && win_wt == sw && win_valid == sv, "R9 hold", win_valid, sv);
    end
    out_ready = 1; in_valid = 0;
    @(posedge clk); #2;
    chk(win_valid == 1'b0, "R9 bubble", win_valid, 0);
    chk(in_ready == 1'b1, "R2 ready high", in_ready, 1);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    tapq[0] = 0; tapq[1] = 0; tapq[2] = 0;
    repeat (3) @(posedge clk);
    #2;
    chk(win_valid == 0, "R1 reset valid", win_valid, 0);
    chk(win_wt == '0, "R1 reset weights", int'(win_wt), 0);
    chk(win_pix == '0, "R1 reset pixels", int'(win_pix[31:0]), 0);
    rst = 0;
    for (int f = 0; f < 4; f++) begin
      for (int y = 0; y < H; y++) begin
        for (int x = 0; x < W; x++) begin
          logic [7:0] ax = PAT[f][39:32], ay = PAT[f][31:24], c0 = PAT[f][23:16];
          logic [7:0] base = PAT[f][15:8], s = PAT[f][7:0];
          logic [7:0] p = 8'(ax*x + ay*y + c0);
          if (f == 2 && y == 4 && x == 5) stall_seq();
          beat(p, 8'(base + (tapq[2] >> s)));
        end
      end
    end
    beat(8'd0, 8'd10);
    in_valid = 0;
    @(posedge clk); #2;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule